// File: doc/BRIEF.md
# Halfword-to-Word Host Data Packer

This block sits between a narrow multiplexed host port and the 32-bit internal side of a host interface. In 16-bit operation the host moves every word as two halfword transfers. The block joins two written halfwords into one 32-bit word, and it splits a 32-bit internal word into two halfwords for host reads. A halfword-select input marks each transfer of a pair as the first or the second.

A configuration input is sampled while reset is held. It selects 16-bit operation or full 32-bit operation. In 32-bit operation each strobe moves a whole word and halfword-select has no effect. An order bit decides which half of a word crosses the bus first. The order bit lives in a small control register that the host reaches through the same port. In 16-bit operation the host may read the control register with a single halfword cycle.

Host strobes arrive as one-cycle pulses that are already synchronised to `clk`. A pulse marks the capture edge of a host cycle. Write data is taken on that edge.

Top module: `hw_word_packer`

## Requirements
- R1: After reset, `word_valid`, `seq_err` and `host_rdata` are 0, and the order bit is 0.
- R2: `cfg_wide` is sampled only while `rst_n` is low: 0 selects 16-bit operation and 1 selects 32-bit operation. Later changes of `cfg_wide` have no effect until the next reset.
- R3: In 16-bit mode, a write with `host_hw`=0 followed by a write with `host_hw`=1 produces one word. `word_valid` rises in the cycle after the second strobe, and `word_kind` takes the access kind of the second transfer. The first transfer alone produces no word. Access kinds: 00 = control, 01 = data with increment, 10 = address, 11 = data. Control writes update the control register and do not raise `word_valid`.
- R4: When the order bit is 0, the first halfword is bits 31:16 of the word. When it is 1, the first halfword is bits 15:0. A completed control write loads the order bit from bit 0 of the word.
- R5: A control read returns the order bit at bit 0 and again at bit 8. All other bits are 0.
- R6: In 16-bit mode, a single control read strobe returns control bits 15:0 on `host_rdata[15:0]`, with bits 31:16 at 0, whatever the value of `host_hw`. It does not disturb a pending write halfword.
- R7: In 16-bit mode, a data or address read with `host_hw`=0 returns the half of `rd_word` chosen by the order bit and holds the other half. The following read with `host_hw`=1 returns that held half, whatever `rd_word` is by then.
- R8: A second-halfword write with no pending first halfword sets `seq_err` and produces no word. `seq_err` stays at 1 until reset.
- R9: In 32-bit mode every write strobe produces a full 32-bit word, or a control update, and every read returns the full word. `host_hw` is ignored.
- R10: `word_valid` is high for exactly one cycle for each completed data or address word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | Width select, sampled during reset |
| host_stb | input | 1 | One-cycle pulse at the capture edge of a host cycle |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_kind | input | 2 | Access kind (00 control, 01 data with increment, 10 address, 11 data) |
| host_hw | input | 1 | Halfword select: 0 = first transfer, 1 = second transfer |
| host_wdata | input | 32 | Host write data; only bits 15:0 are used in 16-bit mode |
| rd_word | input | 32 | Internal word to send on data and address reads |
| host_rdata | output | 32 | Registered read data for the host |
| word_out | output | 32 | Assembled word for the internal side |
| word_kind | output | 2 | Access kind of `word_out` |
| word_valid | output | 1 | One-cycle pulse when `word_out` is new |
| seq_err | output | 1 | Sticky flag for an orphan second halfword |

## Verification
Write pairs are sent with both settings of the order bit. The halves carry distinct patterns, so a swapped or stale half shows up in `word_out`. Reads are split with distinct high and low halves, and `rd_word` is changed before the second transfer, which shows whether the second half is taken from the held copy or read live. A control read is placed between the two halves of a write pair, and another control read is made with each halfword-select value; these show that the single-halfword path leaves the pair state alone. A lone second halfword is followed by a good pair, which separates a discarded orphan from lost state. The 32-bit runs apply both halfword-select values and change `cfg_wide` after reset.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  localparam int HALF_W     = 16;
  localparam int WORD_W     = 2 * HALF_W;
  localparam int ORD_BIT    = 0;
  localparam int ORD_MIRROR = 8;

  typedef enum logic [1:0] {
    ACC_CTRL     = 2'b00,
    ACC_DATA_INC = 2'b01,
    ACC_ADDR     = 2'b10,
    ACC_DATA     = 2'b11
  } acc_kind_e;

  // Put two halfwords back into one word, following the order bit.
  function automatic logic [WORD_W-1:0] join_halves(
    input logic [HALF_W-1:0] first,
    input logic [HALF_W-1:0] second,
    input logic              lsb_first
  );
    return lsb_first ? {second, first} : {first, second};
  endfunction

  function automatic logic [HALF_W-1:0] pick_first(
    input logic [WORD_W-1:0] word,
    input logic              lsb_first
  );
    return lsb_first ? word[HALF_W-1:0] : word[WORD_W-1:HALF_W];
  endfunction

  function automatic logic [HALF_W-1:0] pick_second(
    input logic [WORD_W-1:0] word,
    input logic              lsb_first
  );
    return lsb_first ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
  endfunction

  // Readable image of the control register; the order bit shows in both bytes.
  function automatic logic [WORD_W-1:0] ctrl_image(input logic ord);
    logic [WORD_W-1:0] img;
    img             = '0;
    img[ORD_BIT]    = ord;
    img[ORD_MIRROR] = ord;
    return img;
  endfunction
endpackage

// File: rtl/hwp_ctrl_reg.sv
module hwp_ctrl_reg
  import hwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              ord_in,
  output logic              ord,
  output logic [WORD_W-1:0] img
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ord <= 1'b0;
    else if (we) ord <= ord_in;
  end

  assign img = ctrl_image(ord);
endmodule

// File: rtl/hwp_wr_join.sv
module hwp_wr_join
  import hwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              stb,
  input  logic              rnw,
  input  logic [1:0]        kind,
  input  logic              hw,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ord,
  output logic [WORD_W-1:0] word_out,
  output logic [1:0]        word_kind,
  output logic              word_valid,
  output logic              ctrl_we,
  output logic              ctrl_ord,
  output logic              seq_err,
  output logic              orphan
);
  logic [HALF_W-1:0] hold_q;
  logic              pend_q;
  logic              wr_ev, first_ev, second_ev, complete;
  logic [WORD_W-1:0] full_word;

  assign wr_ev     = stb & ~rnw;
  assign first_ev  = wr_ev & ~wide & ~hw;
  assign second_ev = wr_ev & ~wide & hw;
  assign orphan    = second_ev & ~pend_q;
  assign complete  = (wr_ev & wide) | (second_ev & pend_q);
  assign full_word = wide ? wdata : join_halves(hold_q, wdata[HALF_W-1:0], ord);
  assign ctrl_we   = complete & (kind == ACC_CTRL);
  assign ctrl_ord  = full_word[ORD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend_q <= 1'b0;
    end else if (first_ev) begin
      hold_q <= wdata[HALF_W-1:0];
      pend_q <= 1'b1;
    end else if (second_ev) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out   <= '0;
      word_kind  <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= complete & (kind != ACC_CTRL);
      if (complete && kind != ACC_CTRL) begin
        word_out  <= full_word;
        word_kind <= kind;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seq_err <= 1'b0;
    else if (orphan) seq_err <= 1'b1;
  end
endmodule

// File: rtl/hwp_rd_split.sv
module hwp_rd_split
  import hwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              stb,
  input  logic              rnw,
  input  logic [1:0]        kind,
  input  logic              hw,
  input  logic [WORD_W-1:0] rd_word,
  input  logic [WORD_W-1:0] ctrl_img,
  input  logic              ord,
  output logic [WORD_W-1:0] rdata
);
  logic [HALF_W-1:0] held_q;
  logic              rd_ev;
  logic              is_ctrl;

  assign rd_ev   = stb & rnw;
  assign is_ctrl = (kind == ACC_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      held_q <= '0;
    end else if (rd_ev) begin
      if (wide) begin
        rdata <= is_ctrl ? ctrl_img : rd_word;
      end else if (is_ctrl) begin
        rdata <= {{HALF_W{1'b0}}, ctrl_img[HALF_W-1:0]};
      end else if (!hw) begin
        rdata  <= {{HALF_W{1'b0}}, pick_first(rd_word, ord)};
        held_q <= pick_second(rd_word, ord);
      end else begin
        rdata <= {{HALF_W{1'b0}}, held_q};
      end
    end
  end
endmodule

// File: rtl/hw_word_packer.sv
module hw_word_packer
  import hwp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wide,
  input  logic        host_stb,
  input  logic        host_rnw,
  input  logic [1:0]  host_kind,
  input  logic        host_hw,
  input  logic [31:0] host_wdata,
  input  logic [31:0] rd_word,
  output logic [31:0] host_rdata,
  output logic [31:0] word_out,
  output logic [1:0]  word_kind,
  output logic        word_valid,
  output logic        seq_err
);
  logic              wide_q;
  logic              ord;
  logic [WORD_W-1:0] ctrl_img;
  logic              ctrl_we;
  logic              ctrl_ord;
  logic              orphan;

  // Width select is captured only while reset is asserted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wide_q <= cfg_wide;
    else        wide_q <= wide_q;
  end

  hwp_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (ctrl_we),
    .ord_in (ctrl_ord),
    .ord    (ord),
    .img    (ctrl_img)
  );

  hwp_wr_join u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide       (wide_q),
    .stb        (host_stb),
    .rnw        (host_rnw),
    .kind       (host_kind),
    .hw         (host_hw),
    .wdata      (host_wdata),
    .ord        (ord),
    .word_out   (word_out),
    .word_kind  (word_kind),
    .word_valid (word_valid),
    .ctrl_we    (ctrl_we),
    .ctrl_ord   (ctrl_ord),
    .seq_err    (seq_err),
    .orphan     (orphan)
  );

  hwp_rd_split u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide     (wide_q),
    .stb      (host_stb),
    .rnw      (host_rnw),
    .kind     (host_kind),
    .hw       (host_hw),
    .rd_word  (rd_word),
    .ctrl_img (ctrl_img),
    .ord      (ord),
    .rdata    (host_rdata)
  );
endmodule

// File: rtl/hwp_chk.sv
module hwp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stb,
  input logic        rnw,
  input logic [1:0]  kind,
  input logic        wide,
  input logic        ord,
  input logic        ctrl_we,
  input logic        orphan,
  input logic        word_valid,
  input logic        seq_err,
  input logic [31:0] rdata
);
  // R3
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(stb && !rnw && kind != 2'b00));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

  // R8
  orphan_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    orphan |=> (!word_valid && seq_err));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(wide));

  // R4
  ord_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ord) |-> $past(ctrl_we));

  // R5
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stb && rnw && kind == 2'b00) |-> (rdata[0] == rdata[8]));

  // R6
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stb && rnw) && !wide) |-> (rdata[31:16] == 16'h0000));
endmodule

bind hw_word_packer hwp_chk u_hwp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stb        (host_stb),
  .rnw        (host_rnw),
  .kind       (host_kind),
  .wide       (wide_q),
  .ord        (ord),
  .ctrl_we    (ctrl_we),
  .orphan     (orphan),
  .word_valid (word_valid),
  .seq_err    (seq_err),
  .rdata      (host_rdata)
);

// File: tb/hw_word_packer_bench.sv
module hw_word_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b0;
  logic        host_stb = 1'b0;
  logic        host_rnw = 1'b0;
  logic [1:0]  host_kind = 2'b00;
  logic        host_hw = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] rd_word = '0;
  logic [31:0] host_rdata;
  logic [31:0] word_out;
  logic [1:0]  word_kind;
  logic        word_valid;
  logic        seq_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  hw_word_packer u_hw_word_packer (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .host_stb(host_stb),
    .host_rnw(host_rnw), .host_kind(host_kind), .host_hw(host_hw),
    .host_wdata(host_wdata), .rd_word(rd_word), .host_rdata(host_rdata),
    .word_out(word_out), .word_kind(word_kind), .word_valid(word_valid),
    .seq_err(seq_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic wide);
    @(negedge clk);
    cfg_wide = wide;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One strobe; returns at the next falling edge, when registered outputs are new.
  task automatic strobe(input logic rnw, input logic [1:0] kind, input logic hw,
                        input logic [31:0] wd, input logic [31:0] rw);
    host_stb = 1'b1; host_rnw = rnw; host_kind = kind; host_hw = hw;
    host_wdata = wd; rd_word = rw;
    @(negedge clk);
    host_stb = 1'b0;
  endtask

  task automatic t_reset_state;
    do_reset(1'b0);
    chk("R1 valid", {31'b0, word_valid}, 32'h0);
    chk("R1 seq_err", {31'b0, seq_err}, 32'h0);
    chk("R1 rdata", host_rdata, 32'h0);
    strobe(1'b1, 2'b00, 1'b0, '0, '0);
    chk("R1 order bit zero", host_rdata, 32'h0);
  endtask

  task automatic t_pair_msb_first;
    strobe(1'b0, 2'b11, 1'b0, 32'h0000_AAAA, '0);
    chk("R3 no word after first half", {31'b0, word_valid}, 32'h0);
    strobe(1'b0, 2'b11, 1'b1, 32'h0000_5555, '0);
    chk("R3 valid after second half", {31'b0, word_valid}, 32'h1);
    chk("R4 msb first word", word_out, 32'hAAAA_5555);
    chk("R3 word kind", {30'b0, word_kind}, 32'h3);
    @(negedge clk);
    chk("R10 single cycle valid", {31'b0, word_valid}, 32'h0);
  endtask

  task automatic t_set_order;
    strobe(1'b0, 2'b00, 1'b0, 32'h0000_0000, '0);
    strobe(1'b0, 2'b00, 1'b1, 32'h0000_0001, '0);
    chk("R3 ctrl write gives no word", {31'b0, word_valid}, 32'h0);
    strobe(1'b1, 2'b00, 1'b1, '0, 32'hFFFF_FFFF);
    chk("R5 mirror at bits 0 and 8 (hw=1)", host_rdata, 32'h0000_0101);
    strobe(1'b1, 2'b00, 1'b0, '0, 32'hFFFF_FFFF);
    chk("R6 single ctrl read hw=0", host_rdata, 32'h0000_0101);
  endtask

  task automatic t_pair_lsb_first;
    strobe(1'b0, 2'b10, 1'b0, 32'h0000_1234, '0);
    strobe(1'b0, 2'b10, 1'b1, 32'h0000_BEEF, '0);
    chk("R4 lsb first word", word_out, 32'hBEEF_1234);
    chk("R3 address kind", {30'b0, word_kind}, 32'h2);
  endtask

  task automatic t_ctrl_read_midpair;
    strobe(1'b0, 2'b11, 1'b0, 32'h0000_1111, '0);
    strobe(1'b1, 2'b00, 1'b0, '0, '0);
    chk("R6 ctrl read inside pair", host_rdata, 32'h0000_0101);
    strobe(1'b0, 2'b11, 1'b1, 32'h0000_2222, '0);
    chk("R6 pair survives ctrl read", word_out, 32'h2222_1111);
    chk("R6 valid after pair", {31'b0, word_valid}, 32'h1);
  endtask

  task automatic t_read_split;
    strobe(1'b1, 2'b11, 1'b0, '0, 32'hCAFE_F00D);
    chk("R7 first half lsb order", host_rdata, 32'h0000_F00D);
    strobe(1'b1, 2'b11, 1'b1, '0, 32'h0000_0000);
    chk("R7 held second half", host_rdata, 32'h0000_CAFE);
    strobe(1'b0, 2'b00, 1'b0, 32'h0, '0);
    strobe(1'b0, 2'b00, 1'b1, 32'h0, '0);
    strobe(1'b1, 2'b00, 1'b0, '0, '0);
    chk("R4 order cleared", host_rdata, 32'h0);
    strobe(1'b1, 2'b10, 1'b0, '0, 32'hCAFE_F00D);
    chk("R7 first half msb order", host_rdata, 32'h0000_CAFE);
    strobe(1'b1, 2'b10, 1'b1, '0, 32'h1234_5678);
    chk("R7 held low half", host_rdata, 32'h0000_F00D);
  endtask

  task automatic t_orphan;
    strobe(1'b0, 2'b11, 1'b1, 32'h0000_9999, '0);
    chk("R8 orphan no word", {31'b0, word_valid}, 32'h0);
    chk("R8 seq_err set", {31'b0, seq_err}, 32'h1);
    strobe(1'b0, 2'b01, 1'b0, 32'h0000_DEAD, '0);
    strobe(1'b0, 2'b01, 1'b1, 32'h0000_BEEF, '0);
    chk("R8 later pair intact", word_out, 32'hDEAD_BEEF);
    chk("R8 seq_err sticky", {31'b0, seq_err}, 32'h1);
  endtask

  task automatic t_wide;
    do_reset(1'b1);
    chk("R1 seq_err after reset", {31'b0, seq_err}, 32'h0);
    cfg_wide = 1'b0;
    strobe(1'b0, 2'b01, 1'b1, 32'h89AB_CDEF, '0);
    chk("R9 full word hw=1", word_out, 32'h89AB_CDEF);
    chk("R9 valid hw=1", {31'b0, word_valid}, 32'h1);
    chk("R2 cfg change ignored", {31'b0, seq_err}, 32'h0);
    strobe(1'b0, 2'b11, 1'b0, 32'h0246_8ACE, '0);
    chk("R9 full word hw=0", word_out, 32'h0246_8ACE);
    chk("R10 valid on back-to-back word", {31'b0, word_valid}, 32'h1);
    strobe(1'b1, 2'b11, 1'b1, '0, 32'h1357_9BDF);
    chk("R9 full read", host_rdata, 32'h1357_9BDF);
    strobe(1'b0, 2'b00, 1'b0, 32'h0000_0001, '0);
    strobe(1'b1, 2'b00, 1'b0, '0, '0);
    chk("R5 wide ctrl read", host_rdata, 32'h0000_0101);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_pair_msb_first();
    t_set_order();
    t_pair_lsb_first();
    t_ctrl_read_midpair();
    t_read_split();
    t_orphan();
    t_wide();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule